// File: doc/BRIEF.md
# Trigger-Latched Real-Time Output Buffer

This block holds preset data for a 6-bit output port and moves that data onto the port only when a trigger pulse arrives, so the moment the pins change is set by an external event and not by the time at which software writes. Software fills two buffer halves through a small register bus: a 4-bit low half and a 2-bit high half. Each half has its own address. A read at either address returns both halves together.

A mode input selects one of two arrangements. In split mode the port is two independent channels: a 4-bit channel driven by `trig_lo` and a 2-bit channel driven by `trig_hi`. Each half is written at its own address. In wide mode the port is one 6-bit channel driven by `trig_lo` alone. A byte write at either address then loads both halves at once. The bus accepts byte writes and single-bit writes.

Top module: `rtobuf_top`

## Requirements
- R1: After reset, both buffer halves, `bus_rdata` and `port_out` are all zero.
- R2: In split mode (`wide_mode`=0), a byte write (`bus_we`=1, `bus_bit_en`=0) with `bus_addr[1]`=0 loads `bus_wdata[3:0]` into the low half and leaves the high half unchanged.
- R3: In split mode, a byte write with `bus_addr[1]`=1 loads `bus_wdata[5:4]` into the high half and leaves the low half unchanged.
- R4: In wide mode (`wide_mode`=1), a byte write at either address loads `bus_wdata[3:0]` into the low half and `bus_wdata[5:4]` into the high half in the same cycle.
- R5: `bus_rdata` is `{2'b00, high[1:0], low[3:0]}` whatever the value of `bus_addr`.
- R6: Write data in bit positions 7 and 6 is discarded, and `bus_rdata[7:6]` always reads 0.
- R7: A single-bit write (`bus_we`=1, `bus_bit_en`=1) sets combined bit position `bus_bit_sel` to `bus_wdata[0]`. It takes effect only if the address owns that position: positions 0..3 at `bus_addr[1]`=0, positions 4..5 at `bus_addr[1]`=1, and positions 0..5 at either address in wide mode. Any other bit write leaves the buffer unchanged.
- R8: In split mode, `trig_lo` copies the low half into `port_out[3:0]` and `trig_hi` copies the high half into `port_out[5:4]`. Each trigger acts only on its own field and takes effect at the clock edge that samples it.
- R9: In wide mode, `trig_lo` copies all six buffer bits into `port_out` in one edge, and `trig_hi` has no effect.
- R10: When a write and a trigger occur in the same cycle, the port takes the buffer value from before the write, and the written value is kept for the next trigger.
- R11: With no effective trigger, `port_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wide_mode | input | 1 | 0: split 4+2 channels, 1: one 6-bit channel |
| bus_addr | input | 2 | Register address; bit 1 selects the high half |
| bus_we | input | 1 | Write strobe |
| bus_bit_en | input | 1 | 1: single-bit write, 0: byte write |
| bus_bit_sel | input | 3 | Combined bit position for a single-bit write |
| bus_wdata | input | 8 | Write data; bit 0 is the value for a single-bit write |
| bus_rdata | output | 8 | Combined read view of both halves |
| trig_lo | input | 1 | Trigger for the low channel, or for all six bits in wide mode |
| trig_hi | input | 1 | Trigger for the high channel in split mode |
| port_out | output | 6 | Latched output port |

## Verification
A bus write and a trigger can land in the same clock cycle, and that is the case this block has to decide. The bench provokes it in both modes: it writes new data to a half while firing the trigger that loads that half. It then requires that the port shows the previous buffer contents and that the read view already shows the new data. A later trigger must move the new data onto the port. The checker states the same rule as a property: after any trigger, the port equals the read view from the cycle before.

// File: rtl/rtobuf_pkg.sv
package rtobuf_pkg;
  localparam int unsigned BUS_W = 8;
  localparam int unsigned SEL_W = $clog2(BUS_W);

  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_WIDE  = 1'b1
  } rto_mode_e;
endpackage

// File: rtl/rtobuf_rstsync.sv
module rtobuf_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rtobuf_decode.sv
module rtobuf_decode
  import rtobuf_pkg::*;
#(
  parameter int unsigned LO_W = 4,
  parameter int unsigned HI_W = 2
) (
  input  rto_mode_e         mode,
  input  logic              sel_high,
  input  logic              we,
  input  logic              bit_en,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic [BUS_W-1:0]  wdata,
  output logic [LO_W-1:0]   lo_wen,
  output logic [LO_W-1:0]   lo_wval,
  output logic [HI_W-1:0]   hi_wen,
  output logic [HI_W-1:0]   hi_wval
);
  logic lo_owned;
  logic hi_owned;

  always_comb begin
    lo_owned = (mode == MODE_WIDE) || !sel_high;
    hi_owned = (mode == MODE_WIDE) ||  sel_high;
  end

  for (genvar i = 0; i < LO_W; i++) begin : g_lo
    always_comb begin
      lo_wval[i] = bit_en ? wdata[0] : wdata[i];
      lo_wen[i]  = we && lo_owned && (!bit_en || (bit_sel == SEL_W'(i)));
    end
  end

  for (genvar j = 0; j < HI_W; j++) begin : g_hi
    always_comb begin
      hi_wval[j] = bit_en ? wdata[0] : wdata[LO_W+j];
      hi_wen[j]  = we && hi_owned && (!bit_en || (bit_sel == SEL_W'(LO_W + j)));
    end
  end
endmodule

// File: rtl/rtobuf_buffer.sv
module rtobuf_buffer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wen,
  input  logic [W-1:0] wval,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    for (int k = 0; k < W; k++) begin
      d[k] = wen[k] ? wval[k] : q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (|wen)  q <= d;
  end
endmodule

// File: rtl/rtobuf_latch.sv
module rtobuf_latch
  import rtobuf_pkg::*;
#(
  parameter int unsigned LO_W = 4,
  parameter int unsigned HI_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rto_mode_e       mode,
  input  logic            trig_lo,
  input  logic            trig_hi,
  input  logic [LO_W-1:0] lo_q,
  input  logic [HI_W-1:0] hi_q,
  output logic [LO_W-1:0] out_lo,
  output logic [HI_W-1:0] out_hi
);
  logic            ld_lo;
  logic            ld_hi;
  logic [LO_W-1:0] lo_d;
  logic [HI_W-1:0] hi_d;

  always_comb begin
    ld_lo = trig_lo;
    ld_hi = (mode == MODE_WIDE) ? trig_lo : trig_hi;
    lo_d  = ld_lo ? lo_q : out_lo;
    hi_d  = ld_hi ? hi_q : out_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_lo <= '0;
      out_hi <= '0;
    end else if (ld_lo || ld_hi) begin
      out_lo <= lo_d;
      out_hi <= hi_d;
    end
  end
endmodule

// File: rtl/rtobuf_top.sv
module rtobuf_top
  import rtobuf_pkg::*;
#(
  parameter int unsigned LO_W   = 4,
  parameter int unsigned HI_W   = 2,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wide_mode,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic                  bus_we,
  input  logic                  bus_bit_en,
  input  logic [SEL_W-1:0]      bus_bit_sel,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic                  trig_lo,
  input  logic                  trig_hi,
  output logic [LO_W+HI_W-1:0]  port_out
);
  localparam int unsigned OUT_W    = LO_W + HI_W;
  localparam int unsigned HI_SEL_B = 1;
  localparam int unsigned PAD_W    = BUS_W - OUT_W;

  logic            rst_q_n;
  rto_mode_e       mode;
  logic [LO_W-1:0] lo_wen, lo_wval, lo_q, out_lo;
  logic [HI_W-1:0] hi_wen, hi_wval, hi_q, out_hi;

  assign mode = rto_mode_e'(wide_mode);

  rtobuf_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  rtobuf_decode #(.LO_W(LO_W), .HI_W(HI_W)) u_dec (
    .mode     (mode),
    .sel_high (bus_addr[HI_SEL_B]),
    .we       (bus_we),
    .bit_en   (bus_bit_en),
    .bit_sel  (bus_bit_sel),
    .wdata    (bus_wdata),
    .lo_wen   (lo_wen),
    .lo_wval  (lo_wval),
    .hi_wen   (hi_wen),
    .hi_wval  (hi_wval)
  );

  rtobuf_buffer #(.W(LO_W)) u_buf_lo (
    .clk (clk), .rst_n (rst_q_n), .wen (lo_wen), .wval (lo_wval), .q (lo_q)
  );

  rtobuf_buffer #(.W(HI_W)) u_buf_hi (
    .clk (clk), .rst_n (rst_q_n), .wen (hi_wen), .wval (hi_wval), .q (hi_q)
  );

  rtobuf_latch #(.LO_W(LO_W), .HI_W(HI_W)) u_latch (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .mode    (mode),
    .trig_lo (trig_lo),
    .trig_hi (trig_hi),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .out_lo  (out_lo),
    .out_hi  (out_hi)
  );

  assign bus_rdata = {{PAD_W{1'b0}}, hi_q, lo_q};
  assign port_out  = {out_hi, out_lo};
endmodule

// File: rtl/rtobuf_chk.sv
module rtobuf_chk #(
  parameter int unsigned LO_W = 4,
  parameter int unsigned HI_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wide_mode,
  input logic [1:0]           bus_addr,
  input logic                 bus_we,
  input logic                 bus_bit_en,
  input logic [7:0]           bus_wdata,
  input logic [7:0]           bus_rdata,
  input logic                 trig_lo,
  input logic                 trig_hi,
  input logic [LO_W+HI_W-1:0] port_out
);
  localparam int unsigned OUT_W = LO_W + HI_W;

  // R2: split low write leaves the high half alone
  a_r2_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && bus_we && !bus_bit_en && !bus_addr[1])
      |=> bus_rdata[OUT_W-1:LO_W] == $past(bus_rdata[OUT_W-1:LO_W]));

  // R3: split high write leaves the low half alone
  a_r3_high_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && bus_we && !bus_bit_en && bus_addr[1])
      |=> bus_rdata[LO_W-1:0] == $past(bus_rdata[LO_W-1:0]));

  // R4: wide byte write loads all six bits
  a_r4_wide_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && bus_we && !bus_bit_en)
      |=> bus_rdata[OUT_W-1:0] == $past(bus_wdata[OUT_W-1:0]));

  // R6: unused positions read as zero
  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7:OUT_W] == '0);

  // R8, R10: a split low trigger moves the pre-edge low half
  a_r8_lo_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && trig_lo)
      |=> port_out[LO_W-1:0] == $past(bus_rdata[LO_W-1:0]));

  // R8, R10: a split high trigger moves the pre-edge high half
  a_r8_hi_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_mode && trig_hi)
      |=> port_out[OUT_W-1:LO_W] == $past(bus_rdata[OUT_W-1:LO_W]));

  // R9, R10: wide trigger moves all six pre-edge bits
  a_r9_wide_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && trig_lo)
      |=> port_out == $past(bus_rdata[OUT_W-1:0]));

  // R9: the high trigger alone does nothing in wide mode
  a_r9_hi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_mode && trig_hi && !trig_lo) |=> $stable(port_out));

  // R11: no trigger, no change
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_lo && !trig_hi) |=> $stable(port_out));
endmodule

bind rtobuf_top rtobuf_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .wide_mode  (wide_mode),
  .bus_addr   (bus_addr[1:0]),
  .bus_we     (bus_we),
  .bus_bit_en (bus_bit_en),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .trig_lo    (trig_lo),
  .trig_hi    (trig_hi),
  .port_out   (port_out)
);

// File: tb/tb_rtobuf_top.sv
module tb_rtobuf_top;
  logic       clk;
  logic       rst_n;
  logic       wide_mode;
  logic [1:0] bus_addr;
  logic       bus_we;
  logic       bus_bit_en;
  logic [2:0] bus_bit_sel;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       trig_lo;
  logic       trig_hi;
  logic [5:0] port_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  rtobuf_top dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_bit_en(bus_bit_en), .bus_bit_sel(bus_bit_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_lo(trig_lo),
    .trig_hi(trig_hi), .port_out(port_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Vector: {wide, we, bit_en, addr1, sel[2:0], wdata[7:0], tlo, thi, exp_rd[7:0], exp_port[5:0]}
  localparam int NV = 18;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,1'b0,3'd0,8'hFA,1'b0,1'b0,8'h0A,6'h00}, // 0  R2
    {1'b0,1'b1,1'b0,1'b1,3'd0,8'hE7,1'b0,1'b0,8'h2A,6'h00}, // 1  R3 R6
    {1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,8'h2A,6'h0A}, // 2  R8
    {1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b1,8'h2A,6'h2A}, // 3  R8
    {1'b0,1'b1,1'b0,1'b0,3'd0,8'h05,1'b1,1'b0,8'h25,6'h2A}, // 4  R10
    {1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b0,8'h25,6'h2A}, // 5  R11
    {1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,8'h25,6'h25}, // 6  R8 R10
    {1'b1,1'b1,1'b0,1'b1,3'd0,8'h3C,1'b0,1'b0,8'h3C,6'h25}, // 7  R4
    {1'b1,1'b0,1'b0,1'b0,3'd0,8'h00,1'b0,1'b1,8'h3C,6'h25}, // 8  R9
    {1'b1,1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b0,8'h3C,6'h3C}, // 9  R9
    {1'b1,1'b1,1'b0,1'b0,3'd0,8'hD1,1'b0,1'b0,8'h11,6'h3C}, // 10 R4 R6
    {1'b1,1'b1,1'b0,1'b0,3'd0,8'h2E,1'b1,1'b0,8'h2E,6'h11}, // 11 R10
    {1'b0,1'b1,1'b1,1'b0,3'd3,8'h00,1'b0,1'b0,8'h26,6'h11}, // 12 R7
    {1'b0,1'b1,1'b1,1'b0,3'd5,8'h01,1'b0,1'b0,8'h26,6'h11}, // 13 R7
    {1'b0,1'b1,1'b1,1'b1,3'd4,8'h01,1'b0,1'b0,8'h36,6'h11}, // 14 R7
    {1'b0,1'b1,1'b1,1'b1,3'd7,8'h01,1'b0,1'b0,8'h36,6'h11}, // 15 R6 R7
    {1'b1,1'b1,1'b1,1'b1,3'd0,8'h01,1'b0,1'b0,8'h37,6'h11}, // 16 R7
    {1'b0,1'b0,1'b0,1'b0,3'd0,8'h00,1'b1,1'b1,8'h37,6'h37}  // 17 R8
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R2";   1: return "R3/R6"; 2: return "R8";  3: return "R8";
      4: return "R10";  5: return "R11";   6: return "R8";  7: return "R4";
      8: return "R9";   9: return "R9";    10: return "R4/R6"; 11: return "R10";
      12: return "R7";  13: return "R7";   14: return "R7"; 15: return "R6/R7";
      16: return "R7";  default: return "R8";
    endcase
  endfunction

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    bus_we = 0; bus_bit_en = 0; bus_bit_sel = '0; bus_wdata = '0;
    trig_lo = 0; trig_hi = 0; bus_addr = '0;
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wide_mode = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check8("R1 rdata in reset", bus_rdata, 8'h00);
    check8("R1 port in reset", {2'b00, port_out}, 8'h00);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check8("R1 rdata after release", bus_rdata, 8'h00);
    check8("R1 port after release", {2'b00, port_out}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      wide_mode   = VEC[i][30];
      bus_we      = VEC[i][29];
      bus_bit_en  = VEC[i][28];
      bus_addr    = {VEC[i][27], 1'b0};
      bus_bit_sel = VEC[i][26:24];
      bus_wdata   = VEC[i][23:16];
      trig_lo     = VEC[i][15];
      trig_hi     = VEC[i][14];
      @(negedge clk);
      check8({vtag(i), " rdata"}, bus_rdata, VEC[i][13:6]);
      check8({vtag(i), " port"}, {2'b00, port_out}, {2'b00, VEC[i][5:0]});
    end
    idle_inputs();

    // R5: same read view at both addresses (buffer holds 0x37)
    bus_addr = 2'b00; #1;
    check8("R5 read at low address", bus_rdata, 8'h37);
    bus_addr = 2'b10; #1;
    check8("R5 read at high address", bus_rdata, 8'h37);

    // R10: written value reaches the port at the following trigger (wide)
    @(negedge clk);
    wide_mode = 1; bus_we = 1; bus_addr = 2'b10; bus_wdata = 8'h15; trig_lo = 1;
    @(negedge clk);
    check8("R10 wide same-cycle port", {2'b00, port_out}, 8'h37);
    idle_inputs(); trig_lo = 1;
    @(negedge clk);
    check8("R10 wide next trigger port", {2'b00, port_out}, 8'h15);
    idle_inputs();

    // R11: several idle cycles keep the port
    repeat (5) @(negedge clk);
    check8("R11 hold after idle", {2'b00, port_out}, 8'h15);

    // R1: reset mid-run clears state
    rst_n = 0; #1;
    check8("R1 rdata mid-run reset", bus_rdata, 8'h00);
    check8("R1 port mid-run reset", {2'b00, port_out}, 8'h00);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check8("R1 port after second release", {2'b00, port_out}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule